// File: doc/BRIEF.md
# SDRAM Bank State and Command Legality Monitor

This block sits beside an SDRAM command bus and only listens. At every rising clock edge it decodes the chip-select, row-strobe, column-strobe and write-enable lines, together with the bank and address inputs. It keeps a per-bank model: either idle, or holding an open row whose address it remembers. It also keeps a recovery counter for each bank and one counter for the refresh cycle time. Whenever a command breaks the bank-state or timing rules, it raises a one-cycle error flag, a code and the bank that was addressed.

Precharge, recovery after precharge, refresh cycle time and burst length are all counted in clock cycles and set by parameters. Commands that break a rule are reported and are otherwise treated as if they never happened, so the model stays in step with what a compliant memory would hold. The block also shows which banks are open, the row open in each bank, and the last accepted mode-register value. A bring-up bench or a controller under test can use these outputs directly.

Top module: `sdram_cmd_checker`

## Requirements
- R1: A command counts only at a rising edge where `cke` is high and `cs_n` is low. The command is chosen by {`ras_n`,`cas_n`,`we_n`}: 000 mode load, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 110 burst stop, 111 no-op. An edge with `cke` low or `cs_n` high raises no error and changes no state.
- R2: An activate to a bank that is idle and recovered opens that bank. On the next cycle its `bank_open` bit is set and its 12-bit field of `open_rows` (bank n at bits n*12 upward) holds `addr[11:0]`.
- R3: An activate to a bank that already holds an open row gives error code 3.
- R4: A read or write to an idle, recovered bank gives error code 2.
- R5: A precharge with `addr[10]` low closes only the bank on `ba`. A precharge with `addr[10]` high closes every bank, whatever `ba` holds.
- R6: After a precharge at edge k, every command addressed to an affected bank at edges k+1 to k+TRP-1 gives error code 1. Refresh, mode load and all-bank precharge count as addressing every bank. The same command is legal at edge k+TRP.
- R7: A read or write with `addr[10]` high (auto-precharge) at edge k keeps the bank open through edge k+BURST_LEN. The bank then goes idle. Commands to that bank give code 1 from edge k+1 through edge k+BURST_LEN+TRP-1.
- R8: A mode load while any bank is open gives error code 4. An accepted mode load copies `addr[11:0]` to `mode_reg` on the next cycle.
- R9: A refresh while any bank is open gives error code 5.
- R10: After an accepted refresh at edge j, any command other than no-op at edges j+1 to j+TRC-1 gives error code 6. No-op and inhibit edges are always legal.
- R11: An error is shown one cycle after its edge: `err_valid` high, `err_code`, and `err_bank` equal to the `ba` sampled at that edge. The command leaves bank state, timers and `mode_reg` unchanged. When more than one check applies, code 6 is reported first, then code 1, then the command's own check.
- R12: Burst stop is legal outside the refresh window and changes no bank state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory interface clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable seen by the memory |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 12 | Address bus; bit 10 selects all-bank precharge or auto-precharge |
| err_valid | output | 1 | One-cycle pulse for a rule violation |
| err_code | output | 3 | Violation code (see requirements) |
| err_bank | output | 2 | Bank input sampled with the offending command |
| bank_open | output | 4 | One bit per bank, high while a row is held |
| open_rows | output | 48 | Row held by each bank, 12 bits per bank |
| mode_reg | output | 12 | Last accepted mode-register value |

## Verification
The embedded properties assume `ba`, `addr` and the strobe lines are known whenever `rst` is low. They also assume one command per clock edge, driven half a cycle away from the sampling edge. The bench drives every input on the falling edge and keeps a fully defined no-op on the bus whenever it has nothing to test. The bench deliberately sends illegal sequences: early activates, reads to idle banks, refresh with open rows, and commands inside the refresh window. The properties, however, only constrain the model's own update signals, so illegal traffic never leads them into an assumption.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;

    typedef enum logic [2:0] {
        CMD_LMR = 3'b000,
        CMD_REF = 3'b001,
        CMD_PRE = 3'b010,
        CMD_ACT = 3'b011,
        CMD_WR  = 3'b100,
        CMD_RD  = 3'b101,
        CMD_BST = 3'b110,
        CMD_NOP = 3'b111
    } cmd_e;

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_EARLY    = 3'd1,
        ERR_RW_IDLE  = 3'd2,
        ERR_ACT_OPEN = 3'd3,
        ERR_LMR_OPEN = 3'd4,
        ERR_REF_OPEN = 3'd5,
        ERR_TRC      = 3'd6
    } err_e;

    typedef enum logic [1:0] {
        BK_IDLE   = 2'd0,
        BK_OPEN   = 2'd1,
        BK_APWAIT = 2'd2
    } bank_st_e;

    typedef struct packed {
        logic valid;
        cmd_e op;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic cke, input logic cs_n,
                                        input logic ras_n, input logic cas_n,
                                        input logic we_n);
        cmd_t c;
        c.valid = cke & ~cs_n;
        c.op    = cmd_e'({ras_n, cas_n, we_n});
        return c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_chk_pkg::*;
(
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_t cmd
);
    always_comb begin
        cmd = decode_cmd(cke, cs_n, ras_n, cas_n, we_n);
    end
endmodule

// File: rtl/sdram_trc_timer.sv
module sdram_trc_timer #(
    parameter int TRC = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(TRC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CW'(TRC - 1);
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign busy = (cnt != '0);

    // R10: a refresh is only accepted outside the previous refresh window
    a_r10_start_outside_window: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

    // R10: the window, once open, shrinks by one each edge
    a_r10_window_counts_down: assert property (@(posedge clk) disable iff (rst)
        (busy && !start) |=> (cnt == $past(cnt) - CW'(1)));
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
    import sdram_chk_pkg::*;
#(
    parameter int ROW_W     = 12,
    parameter int TRP       = 3,
    parameter int BURST_LEN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             do_act,
    input  logic             do_close,
    input  logic             do_autopre,
    input  logic [ROW_W-1:0] row_in,
    output logic             row_held,
    output logic             busy,
    output logic [ROW_W-1:0] row_q
);
    localparam int CW = $clog2(max2(TRP, BURST_LEN) + 1);

    bank_st_e       st;
    logic [CW-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= BK_IDLE;
            cnt   <= '0;
            row_q <= '0;
        end else begin
            case (st)
                BK_IDLE: begin
                    if (do_act) begin
                        st    <= BK_OPEN;
                        row_q <= row_in;
                    end else if (do_close) begin
                        cnt <= CW'(TRP - 1);
                    end else if (cnt != '0) begin
                        cnt <= cnt - CW'(1);
                    end
                end
                BK_OPEN: begin
                    if (do_close) begin
                        st  <= BK_IDLE;
                        cnt <= CW'(TRP - 1);
                    end else if (do_autopre) begin
                        st  <= BK_APWAIT;
                        cnt <= CW'(BURST_LEN);
                    end
                end
                BK_APWAIT: begin
                    if (cnt <= CW'(1)) begin
                        st  <= BK_IDLE;
                        cnt <= CW'(TRP - 1);
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                default: begin
                    st  <= BK_IDLE;
                    cnt <= '0;
                end
            endcase
        end
    end

    assign row_held = (st != BK_IDLE);
    assign busy     = (st == BK_APWAIT) || (cnt != '0);

    // R2, R3: the legality logic only opens a bank that is idle and recovered
    a_r3_act_only_from_idle: assert property (@(posedge clk) disable iff (rst)
        do_act |-> (st == BK_IDLE && cnt == '0));

    // R2: an accepted activate leaves the bank holding the sampled row
    a_r2_act_latches_row: assert property (@(posedge clk) disable iff (rst)
        do_act |=> (row_held && row_q == $past(row_in)));

    // R7: auto-precharge is only accepted on a bank with a row open
    a_r7_autopre_from_open: assert property (@(posedge clk) disable iff (rst)
        do_autopre |-> (st == BK_OPEN));

    // R6: a precharge leaves the bank closed and, when TRP exceeds one, recovering
    a_r6_close_starts_recovery: assert property (@(posedge clk) disable iff (rst)
        (do_close && TRP > 1) |=> (!row_held && busy));

    // R11: an unselected, untouched open bank keeps its row
    a_r11_row_stable: assert property (@(posedge clk) disable iff (rst)
        (st == BK_OPEN && !do_close && !do_autopre) |=> $stable(row_q));
endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
    import sdram_chk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 12,
    parameter int ROW_W     = 12,
    parameter int AP_BIT    = 10,
    parameter int TRP       = 3,
    parameter int TRC       = 7,
    parameter int BURST_LEN = 4,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cke,
    input  logic                       cs_n,
    input  logic                       ras_n,
    input  logic                       cas_n,
    input  logic                       we_n,
    input  logic [BA_W-1:0]            ba,
    input  logic [ADDR_W-1:0]          addr,
    output logic                       err_valid,
    output logic [2:0]                 err_code,
    output logic [BA_W-1:0]            err_bank,
    output logic [NUM_BANKS-1:0]       bank_open,
    output logic [NUM_BANKS*ROW_W-1:0] open_rows,
    output logic [ADDR_W-1:0]          mode_reg
);
    cmd_t                 cmd;
    err_e                 err_n;
    logic                 legal;
    logic                 all_sel;
    logic                 trc_busy;
    logic                 trc_start;
    logic [NUM_BANKS-1:0] busy_v;
    logic [NUM_BANKS-1:0] sel_oh;
    logic [NUM_BANKS-1:0] act_v;
    logic [NUM_BANKS-1:0] close_v;
    logic [NUM_BANKS-1:0] ap_v;
    logic [ROW_W-1:0]     row_a [NUM_BANKS];

    sdram_cmd_decode u_dec (
        .cke   (cke),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    assign sel_oh  = NUM_BANKS'(1) << ba;
    assign all_sel = addr[AP_BIT];

    // Rule evaluation, in priority order: refresh window, recovery, command rule
    always_comb begin
        err_n = ERR_NONE;
        if (cmd.valid && cmd.op != CMD_NOP) begin
            if (trc_busy) begin
                err_n = ERR_TRC;
            end else begin
                case (cmd.op)
                    CMD_ACT: begin
                        if (busy_v[ba])         err_n = ERR_EARLY;
                        else if (bank_open[ba]) err_n = ERR_ACT_OPEN;
                    end
                    CMD_RD, CMD_WR: begin
                        if (busy_v[ba])          err_n = ERR_EARLY;
                        else if (!bank_open[ba]) err_n = ERR_RW_IDLE;
                    end
                    CMD_PRE: begin
                        if (all_sel ? (|busy_v) : busy_v[ba]) err_n = ERR_EARLY;
                    end
                    CMD_REF: begin
                        if (|busy_v)         err_n = ERR_EARLY;
                        else if (|bank_open) err_n = ERR_REF_OPEN;
                    end
                    CMD_LMR: begin
                        if (|busy_v)         err_n = ERR_EARLY;
                        else if (|bank_open) err_n = ERR_LMR_OPEN;
                    end
                    default: err_n = ERR_NONE;
                endcase
            end
        end
    end

    assign legal     = cmd.valid && (err_n == ERR_NONE);
    assign act_v     = (legal && cmd.op == CMD_ACT) ? sel_oh : '0;
    assign close_v   = (legal && cmd.op == CMD_PRE) ? (all_sel ? '1 : sel_oh) : '0;
    assign ap_v      = (legal && (cmd.op == CMD_RD || cmd.op == CMD_WR) && all_sel)
                       ? sel_oh : '0;
    assign trc_start = legal && (cmd.op == CMD_REF);

    generate
        for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
            sdram_bank_tracker #(
                .ROW_W     (ROW_W),
                .TRP       (TRP),
                .BURST_LEN (BURST_LEN)
            ) u_bank (
                .clk        (clk),
                .rst        (rst),
                .do_act     (act_v[g]),
                .do_close   (close_v[g]),
                .do_autopre (ap_v[g]),
                .row_in     (addr[ROW_W-1:0]),
                .row_held   (bank_open[g]),
                .busy       (busy_v[g]),
                .row_q      (row_a[g])
            );
            assign open_rows[g*ROW_W +: ROW_W] = row_a[g];
        end
    endgenerate

    sdram_trc_timer #(.TRC(TRC)) u_trc (
        .clk   (clk),
        .rst   (rst),
        .start (trc_start),
        .busy  (trc_busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            err_valid <= 1'b0;
            err_code  <= ERR_NONE;
            err_bank  <= '0;
            mode_reg  <= '0;
        end else begin
            err_valid <= (err_n != ERR_NONE);
            err_code  <= err_n;
            err_bank  <= ba;
            if (legal && cmd.op == CMD_LMR) mode_reg <= addr;
        end
    end

    // R1: gated edges never produce a report
    a_r1_gated_edge_silent: assert property (@(posedge clk) disable iff (rst)
        (!cke || cs_n) |=> !err_valid);

    // R5: an accepted all-bank precharge leaves no bank holding a row
    a_r5_all_close_empties: assert property (@(posedge clk) disable iff (rst)
        (legal && cmd.op == CMD_PRE && all_sel) |=> (bank_open == '0));

    // R8: an accepted mode load shows the sampled address next cycle
    a_r8_mode_loaded: assert property (@(posedge clk) disable iff (rst)
        (legal && cmd.op == CMD_LMR) |=> (mode_reg == $past(addr)));

    // R11: a rejected command leaves the open-bank set unchanged
    a_r11_error_no_update: assert property (@(posedge clk) disable iff (rst)
        (cmd.valid && err_n != ERR_NONE && $countones(busy_v) == 0) |=> $stable(bank_open));

    // R9: a refresh is never accepted with a row held
    a_r9_refresh_all_idle: assert property (@(posedge clk) disable iff (rst)
        trc_start |-> (bank_open == '0));
endmodule

// File: tb/tb_sdram_cmd_checker.sv
module tb_sdram_cmd_checker;
    import sdram_chk_pkg::*;

    localparam int CLK_P = 10;

    typedef struct {
        logic [2:0] code;
        logic [1:0] bank;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cke = 1'b1;
    logic        cs_n = 1'b1;
    logic        ras_n = 1'b1;
    logic        cas_n = 1'b1;
    logic        we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [11:0] addr = '0;
    logic        err_valid;
    logic [2:0]  err_code;
    logic [1:0]  err_bank;
    logic [3:0]  bank_open;
    logic [47:0] open_rows;
    logic [11:0] mode_reg;

    int   n_chk = 0;
    int   n_bad = 0;
    exp_t sbq[$];

    always #(CLK_P/2) clk = ~clk;

    sdram_cmd_checker dut (
        .clk       (clk),
        .rst       (rst),
        .cke       (cke),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .ba        (ba),
        .addr      (addr),
        .err_valid (err_valid),
        .err_code  (err_code),
        .err_bank  (err_bank),
        .bank_open (bank_open),
        .open_rows (open_rows),
        .mode_reg  (mode_reg)
    );

    // Drive one edge's worth of bus, record the expected report
    task automatic raw(input logic k, input logic cs, input cmd_e op,
                       input logic [1:0] b, input logic [11:0] a,
                       input err_e exp, input string tag);
        exp_t e;
        @(negedge clk);
        cke = k;
        cs_n = cs;
        {ras_n, cas_n, we_n} = op;
        ba = b;
        addr = a;
        @(posedge clk);
        #1;
        e.code = exp;
        e.bank = b;
        e.tag  = tag;
        sbq.push_back(e);
    endtask

    task automatic cmd(input cmd_e op, input logic [1:0] b, input logic [11:0] a,
                       input err_e exp, input string tag);
        raw(1'b1, 1'b0, op, b, a, exp, tag);
    endtask

    task automatic nop();
        raw(1'b1, 1'b0, CMD_NOP, 2'd0, 12'd0, ERR_NONE, "R1");
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: compares the report produced for each driven edge
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            n_chk++;
            if (err_valid !== (e.code != 3'd0) || err_code !== e.code ||
                (e.code != 3'd0 && err_bank !== e.bank)) begin
                n_bad++;
                $display("FAIL %s: actual valid=%b code=%0d bank=%0d expected code=%0d bank=%0d",
                         e.tag, err_valid, err_code, err_bank, e.code, e.bank);
            end
        end
    end

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 reset open", 64'(bank_open), 64'h0);
        chk("R1 reset err", 64'(err_valid), 64'h0);
        chk("R8 reset mode", 64'(mode_reg), 64'h0);

        // R2 open bank 0
        cmd(CMD_ACT, 2'd0, 12'h123, ERR_NONE, "R2");
        chk("R2 open", 64'(bank_open), 64'h1);
        chk("R2 row", 64'(open_rows[11:0]), 64'h123);
        // R3 re-activate
        cmd(CMD_ACT, 2'd0, 12'h456, ERR_ACT_OPEN, "R3");
        chk("R11 row kept", 64'(open_rows[11:0]), 64'h123);
        // R4 read idle bank
        cmd(CMD_RD, 2'd1, 12'h000, ERR_RW_IDLE, "R4");
        cmd(CMD_WR, 2'd3, 12'h010, ERR_RW_IDLE, "R4");
        // R1 gating
        raw(1'b0, 1'b0, CMD_RD, 2'd1, 12'h0, ERR_NONE, "R1");
        raw(1'b1, 1'b1, CMD_ACT, 2'd1, 12'h0AA, ERR_NONE, "R1");
        chk("R1 inhibit no open", 64'(bank_open), 64'h1);
        cmd(CMD_ACT, 2'd1, 12'h0AA, ERR_NONE, "R2");
        cmd(CMD_ACT, 2'd2, 12'h055, ERR_NONE, "R2");
        chk("R2 open three", 64'(bank_open), 64'h7);
        chk("R2 row b2", 64'(open_rows[35:24]), 64'h055);
        cmd(CMD_WR, 2'd0, 12'h004, ERR_NONE, "R4");
        cmd(CMD_BST, 2'd0, 12'h0, ERR_NONE, "R12");
        chk("R12 state", 64'(bank_open), 64'h7);

        // R5 single-bank precharge, R6 recovery
        cmd(CMD_PRE, 2'd1, 12'h000, ERR_NONE, "R5");
        chk("R5 single close", 64'(bank_open), 64'h5);
        cmd(CMD_ACT, 2'd1, 12'h0BB, ERR_EARLY, "R6");
        nop();
        cmd(CMD_ACT, 2'd1, 12'h0BB, ERR_NONE, "R6");
        chk("R6 reopen", 64'(bank_open), 64'h7);
        chk("R6 row", 64'(open_rows[23:12]), 64'h0BB);

        cmd(CMD_LMR, 2'd0, 12'h033, ERR_LMR_OPEN, "R8");
        chk("R8 mode kept", 64'(mode_reg), 64'h0);
        cmd(CMD_REF, 2'd2, 12'h000, ERR_REF_OPEN, "R9");

        // R7 auto-precharge on bank 2
        cmd(CMD_RD, 2'd2, 12'h400, ERR_NONE, "R7");
        cmd(CMD_RD, 2'd2, 12'h000, ERR_EARLY, "R7");
        nop();
        nop();
        chk("R7 still open", 64'(bank_open), 64'h7);
        nop();
        chk("R7 closed at burst end", 64'(bank_open), 64'h3);
        nop();
        cmd(CMD_ACT, 2'd2, 12'h077, ERR_EARLY, "R7");
        cmd(CMD_ACT, 2'd2, 12'h077, ERR_NONE, "R7");
        chk("R7 reopen", 64'(bank_open), 64'h7);

        // R5 all-bank precharge, ba ignored
        cmd(CMD_PRE, 2'd3, 12'h400, ERR_NONE, "R5");
        chk("R5 all close", 64'(bank_open), 64'h0);
        cmd(CMD_ACT, 2'd3, 12'h001, ERR_EARLY, "R6");
        nop();
        cmd(CMD_LMR, 2'd0, 12'h237, ERR_NONE, "R8");
        chk("R8 mode load", 64'(mode_reg), 64'h237);

        // R10 refresh window, R11 priority over R4
        cmd(CMD_REF, 2'd0, 12'h000, ERR_NONE, "R10");
        nop();
        raw(1'b1, 1'b1, CMD_ACT, 2'd0, 12'h0, ERR_NONE, "R10");
        cmd(CMD_RD, 2'd1, 12'h000, ERR_TRC, "R11");
        nop();
        cmd(CMD_BST, 2'd0, 12'h000, ERR_TRC, "R10");
        cmd(CMD_ACT, 2'd0, 12'h011, ERR_TRC, "R10");
        cmd(CMD_ACT, 2'd0, 12'h022, ERR_NONE, "R10");
        chk("R10 open after window", 64'(open_rows[11:0]), 64'h022);

        // R5: precharge on another bank during a write auto-precharge
        cmd(CMD_WR, 2'd0, 12'h408, ERR_NONE, "R7");
        cmd(CMD_PRE, 2'd1, 12'h000, ERR_NONE, "R5");
        cmd(CMD_PRE, 2'd0, 12'h000, ERR_EARLY, "R7");

        nop();
        nop();
        @(negedge clk);
        #1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule